// File: doc/BRIEF.md
# Translation Context Register Bank with Fault Capture

This block holds the software-visible state of a single translation context in an I/O memory management unit. A host reaches it through a plain 32-bit register port with byte offsets inside a 64-byte window. The port sets the context control word, the translation table base and its control word, a bus control word and two memory-attribute words. The table base and table control word drive the page-table walker continuously.

The translation side reports faults on a strobe. Each report carries flag bits, an error code, a table level and the faulting address. The block latches the first fault and merges the flags of any later faults into it until software clears them. It raises an interrupt while interrupts are enabled and any error flag is set.

A TLB invalidation is started by setting the flush bit in the control word. The block sends one request pulse to the TLB. The flush bit then stays readable as 1 until the TLB returns a one-cycle completion, so software can poll it.

Top module: `xlt_ctx_regs`

## Requirements
- R1: After reset every register reads 0, and `irq`, `tlb_inv_req` and `xlt_en` are 0.
- R2: A read returns its data on `rdata` in the cycle after `rd_en`. The configuration words read back exactly what was written: table control at 0x08, bus control at 0x0C, table base low at 0x10, table base high at 0x14, attribute words at 0x28 and 0x2C. Any offset that is not mapped reads 0. `tbl_base` is {high, low} and `tbl_ctl` mirrors 0x08.
- R3: The control word at 0x00 stores bits 0 (translate enable, drives `xlt_en`), 2 (interrupt enable), 3, 16 and 17. All other bits except bit 1 read 0. Writing the word as 0 disables translation.
- R4: Writing 1 to control bit 1 while no flush is pending drives `tlb_inv_req` high for exactly the one cycle after the write. Bit 1 then reads 1.
- R5: While a flush is pending, writing bit 1 as 1 produces no new request pulse, and writing it as 0 does not cancel the pending flush.
- R6: A one-cycle `tlb_inv_done` ends the pending flush, and bit 1 reads 0 afterwards.
- R7: When no error flag is set, a fault report with a nonzero flag set is captured into the status word at 0x20 and the fault address at 0x24. The status word uses bit 0 for translation fault, bit 1 for page fault, bit 2 for walk abort, bit 4 for multiple hit, bits [10:8] for the error code and bits [13:12] for the table level. `flt_flags` is ordered {multi-hit, abort, page, translation}.
- R8: A fault report that arrives while flags are already set ORs in only its flags. The earlier address, code and level are kept.
- R9: Writing 0 to the status word clears all flags, the code and the level, and the fault address then reads 0. A nonzero write to the status word changes nothing.
- R10: `irq` is high exactly while interrupt enable is 1 and any error flag is set. It is low in the cycle after a clearing status write.
- R11: A fault report in the same cycle as a clearing status write is captured as a fresh first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset within the context window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| flt_valid | input | 1 | Fault report strobe |
| flt_flags | input | 4 | {multi-hit, abort, page, translation} |
| flt_code | input | 3 | Error code of the fault |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | 32 | Faulting address |
| tlb_inv_done | input | 1 | One-cycle invalidation completion |
| tlb_inv_req | output | 1 | One-cycle invalidation request |
| xlt_en | output | 1 | Translation enable |
| irq | output | 1 | Fault interrupt |
| tbl_base | output | 64 | Translation table base |
| tbl_ctl | output | 32 | Table control word |

## Verification
The bench targets four hazards in the flush handshake and the fault path. A flush bit written again while pending must not emit a second pulse. A design that re-pulses would invalidate the TLB twice. A design that clears the bit on a 0 write would let software stop polling too early. A second fault must not overwrite the first address, because the handler would then report the wrong location. A nonzero status write must be ignored, since a write-one-to-clear design would silently drop errors. A fault that coincides with the clear must survive, or that fault would be lost without any interrupt.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  // word indices (byte offset / 4) inside the context window
  localparam logic [3:0] W_CTRL  = 4'd0;
  localparam logic [3:0] W_TCTL  = 4'd2;
  localparam logic [3:0] W_BUS   = 4'd3;
  localparam logic [3:0] W_TBLO  = 4'd4;
  localparam logic [3:0] W_TBHI  = 4'd5;
  localparam logic [3:0] W_STAT  = 4'd8;
  localparam logic [3:0] W_FADR  = 4'd9;
  localparam logic [3:0] W_ATTR0 = 4'd10;
  localparam logic [3:0] W_ATTR1 = 4'd11;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_FLUSH = 1;
  localparam int CB_INTEN = 2;
  localparam int CB_TLBEN = 3;
  localparam int CB_SWAF  = 16;
  localparam int CB_TLBX  = 17;

  // status word field positions
  localparam int SB_MHIT  = 4;
  localparam int SB_CODE  = 8;
  localparam int SB_LVL   = 12;

  localparam int NFLAG    = 4;
  localparam int CODE_W   = 3;
  localparam int LVL_W    = 2;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tlb_inv_done,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              xlt_en,
  output logic              inten,
  output logic              tlb_inv_req
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << CB_EN) | (DATA_W'(1) << CB_INTEN) | (DATA_W'(1) << CB_TLBEN) |
    (DATA_W'(1) << CB_SWAF) | (DATA_W'(1) << CB_TLBX);

  logic [DATA_W-1:0] cfg_q;
  logic              pend_q;
  logic              req_q;
  logic              start;

  assign start = wr_en & wdata[CB_FLUSH] & (~pend_q | tlb_inv_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= wdata & KEEP_MASK;
      if (start)             pend_q <= 1'b1;
      else if (tlb_inv_done) pend_q <= 1'b0;
      req_q <= start;
    end
  end

  assign ctrl_word   = cfg_q | (DATA_W'(pend_q) << CB_FLUSH);
  assign xlt_en      = cfg_q[CB_EN];
  assign inten       = cfg_q[CB_INTEN];
  assign tlb_inv_req = req_q;

  // R4: request lasts a single cycle
  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    tlb_inv_req |=> !tlb_inv_req);
  // R4: a request is always accompanied by a pending flush
  p_req_pending_r4: assert property (@(posedge clk) disable iff (rst)
    tlb_inv_req |-> pend_q);
  // R5: pending flush holds until completion
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !tlb_inv_done) |=> pend_q);
  // R6: completion without a new start ends the flush
  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (tlb_inv_done && !(wr_en && wdata[CB_FLUSH])) |=> !pend_q);
endmodule

// File: rtl/ctx_fault.sv
module ctx_fault
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flt_valid,
  input  logic [NFLAG-1:0]  flt_flags,
  input  logic [CODE_W-1:0] flt_code,
  input  logic [LVL_W-1:0]  flt_level,
  input  logic [DATA_W-1:0] flt_addr,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] fault_addr,
  output logic              any_err
);
  logic [NFLAG-1:0]  flags_q;
  logic [CODE_W-1:0] code_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] addr_q;
  logic              clr;
  logic              hit;
  logic              fresh;

  assign clr   = stat_wr && (wdata == '0);
  assign hit   = flt_valid && (flt_flags != '0);
  assign fresh = (flags_q == '0) || clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      code_q  <= '0;
      lvl_q   <= '0;
      addr_q  <= '0;
    end else if (hit) begin
      if (fresh) begin
        flags_q <= flt_flags;
        code_q  <= flt_code;
        lvl_q   <= flt_level;
        addr_q  <= flt_addr;
      end else begin
        flags_q <= flags_q | flt_flags;
      end
    end else if (clr) begin
      flags_q <= '0;
      code_q  <= '0;
      lvl_q   <= '0;
      addr_q  <= '0;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[2:0]                 = flags_q[2:0];
    stat_word[SB_MHIT]             = flags_q[3];
    stat_word[SB_CODE +: CODE_W]   = code_q;
    stat_word[SB_LVL +: LVL_W]     = lvl_q;
  end
  assign fault_addr = addr_q;
  assign any_err    = |flags_q;

  // R8: merging a later fault keeps the captured address
  p_keep_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && (flags_q != '0) && !stat_wr) |=> $stable(addr_q));
  // R9: a clearing write with no new fault empties the record
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !flt_valid) |=> (flags_q == '0 && addr_q == '0));
  // R9: nonzero writes leave the flags alone
  p_nz_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !clr && !flt_valid) |=> $stable(flags_q));
endmodule

// File: rtl/ctx_cfg_bank.sv
module ctx_cfg_bank
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [2*DATA_W-1:0] tbl_base,
  output logic [DATA_W-1:0] tbl_ctl
);
  localparam int NCFG = 6;

  function automatic logic [IDX_W-1:0] slot_idx(input int k);
    case (k)
      0:       return IDX_W'(W_TCTL);
      1:       return IDX_W'(W_BUS);
      2:       return IDX_W'(W_TBLO);
      3:       return IDX_W'(W_TBHI);
      4:       return IDX_W'(W_ATTR0);
      default: return IDX_W'(W_ATTR1);
    endcase
  endfunction

  logic [DATA_W-1:0] cfg_q [NCFG];

  for (genvar k = 0; k < NCFG; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                cfg_q[k] <= '0;
      else if (wr_en && idx == slot_idx(k))   cfg_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCFG; k++)
      if (rd_idx == slot_idx(k)) rd_data = cfg_q[k];
  end

  assign tbl_base = {cfg_q[3], cfg_q[2]};
  assign tbl_ctl  = cfg_q[0];

  // R2: a write to the table control word is visible on the next cycle
  p_tctl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(W_TCTL)) |=> (tbl_ctl == $past(wdata)));
endmodule

// File: rtl/xlt_ctx_regs.sv
module xlt_ctx_regs
  import ctx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                flt_valid,
  input  logic [NFLAG-1:0]    flt_flags,
  input  logic [CODE_W-1:0]   flt_code,
  input  logic [LVL_W-1:0]    flt_level,
  input  logic [DATA_W-1:0]   flt_addr,
  input  logic                tlb_inv_done,
  output logic                tlb_inv_req,
  output logic                xlt_en,
  output logic                irq,
  output logic [2*DATA_W-1:0] tbl_base,
  output logic [DATA_W-1:0]   tbl_ctl
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ctrl_word, stat_word, fault_addr, cfg_rd, rd_mux, rdata_q;
  logic              inten, any_err, ctrl_wr, stat_wr;

  assign idx     = addr[ADDR_W-1:2];
  assign ctrl_wr = wr_en && idx == IDX_W'(W_CTRL);
  assign stat_wr = wr_en && idx == IDX_W'(W_STAT);

  ctx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(wdata),
    .tlb_inv_done(tlb_inv_done), .ctrl_word(ctrl_word), .xlt_en(xlt_en),
    .inten(inten), .tlb_inv_req(tlb_inv_req)
  );

  ctx_fault #(.DATA_W(DATA_W)) u_fault (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .wdata(wdata),
    .flt_valid(flt_valid), .flt_flags(flt_flags), .flt_code(flt_code),
    .flt_level(flt_level), .flt_addr(flt_addr), .stat_word(stat_word),
    .fault_addr(fault_addr), .any_err(any_err)
  );

  ctx_cfg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
    .rd_idx(idx), .rd_data(cfg_rd), .tbl_base(tbl_base), .tbl_ctl(tbl_ctl)
  );

  always_comb begin
    if      (idx == IDX_W'(W_CTRL)) rd_mux = ctrl_word;
    else if (idx == IDX_W'(W_STAT)) rd_mux = stat_word;
    else if (idx == IDX_W'(W_FADR)) rd_mux = fault_addr;
    else                            rd_mux = cfg_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;

  assign irq = inten & any_err;

  // R10: a clearing status write with no fault drops the interrupt
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata == '0 && !flt_valid) |=> !irq);
  // R3: writing the control word as zero disables translation
  p_disable_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata == '0) |=> !xlt_en);
endmodule

// File: tb/xlt_ctx_regs_tb.sv
`timescale 1ns/1ps
module xlt_ctx_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        flt_valid = 0;
  logic [3:0]  flt_flags = '0;
  logic [2:0]  flt_code = '0;
  logic [1:0]  flt_level = '0;
  logic [31:0] flt_addr = '0;
  logic        tlb_inv_done = 0;
  logic        tlb_inv_req, xlt_en, irq;
  logic [63:0] tbl_base;
  logic [31:0] tbl_ctl;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xlt_ctx_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flt_valid(flt_valid), .flt_flags(flt_flags),
    .flt_code(flt_code), .flt_level(flt_level), .flt_addr(flt_addr),
    .tlb_inv_done(tlb_inv_done), .tlb_inv_req(tlb_inv_req), .xlt_en(xlt_en),
    .irq(irq), .tbl_base(tbl_base), .tbl_ctl(tbl_ctl)
  );

  // {offset, write data, expected read}
  localparam int NVEC = 10;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h08, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {8'h0C, 32'h0000_0007, 32'h0000_0007},
    {8'h10, 32'h1234_5000, 32'h1234_5000},
    {8'h14, 32'h0000_00AB, 32'h0000_00AB},
    {8'h28, 32'h0004_FF44, 32'h0004_FF44},
    {8'h2C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h00, 32'hFFFF_FFFD, 32'h0003_000D},
    {8'h3C, 32'h0000_0001, 32'h0000_0000},
    {8'h20, 32'h0000_0005, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic fault(input logic [3:0] f, input logic [2:0] c,
                       input logic [1:0] l, input logic [31:0] a);
    @(negedge clk); flt_valid = 1; flt_flags = f; flt_code = c; flt_level = l; flt_addr = a;
    @(negedge clk); flt_valid = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(6'h00, d); check("R1 ctrl", d, 0);
    rd(6'h20, d); check("R1 status", d, 0);
    rd(6'h24, d); check("R1 faddr", d, 0);
    check("R1 outs", {irq, tlb_inv_req, xlt_en}, 0);

    // R2/R3/R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], d);
      check($sformatf("R2/R3 vec%0d", i), d, VEC[i][31:0]);
    end
    check("R2 tbl_base", tbl_base, 64'h0000_00AB_1234_5000);
    check("R2 tbl_ctl", tbl_ctl, 32'hA5A5_0F0F);
    check("R3 disabled", xlt_en, 0);

    // R4 flush start
    wr(6'h00, 32'h7);
    check("R4 req pulse", tlb_inv_req, 1);
    @(negedge clk); check("R4 req ends", tlb_inv_req, 0);
    check("R3 enable", xlt_en, 1);
    rd(6'h00, d); check("R4 flush pending", d, 32'h7);
    // R5 no re-pulse, no cancel
    wr(6'h00, 32'h7); check("R5 no repulse", tlb_inv_req, 0);
    wr(6'h00, 32'h5);
    rd(6'h00, d); check("R5 not cancelled", d, 32'h7);
    // R6 completion
    @(negedge clk); tlb_inv_done = 1;
    @(negedge clk); tlb_inv_done = 0;
    rd(6'h00, d); check("R6 flush done", d, 32'h5);

    // R7 capture
    fault(4'b0001, 3'd1, 2'd2, 32'hCAFE_0000);
    rd(6'h20, d); check("R7 status", d, 32'h2101);
    rd(6'h24, d); check("R7 faddr", d, 32'hCAFE_0000);
    check("R10 irq set", irq, 1);
    // R8 merge
    fault(4'b1000, 3'd4, 2'd1, 32'h1111_0000);
    rd(6'h20, d); check("R8 status merged", d, 32'h2111);
    rd(6'h24, d); check("R8 faddr kept", d, 32'hCAFE_0000);
    // R9 nonzero ignored, zero clears
    wr(6'h20, 32'h1);
    rd(6'h20, d); check("R9 nonzero ignored", d, 32'h2111);
    check("R9 irq held", irq, 1);
    wr(6'h20, 32'h0);
    check("R10 irq drops", irq, 0);
    rd(6'h20, d); check("R9 status cleared", d, 0);
    rd(6'h24, d); check("R9 faddr zero", d, 0);

    // R10 gated by interrupt enable
    wr(6'h00, 32'h1);
    fault(4'b0010, 3'd4, 2'd0, 32'h0000_2000);
    check("R10 irq gated", irq, 0);
    rd(6'h20, d); check("R10 status", d, 32'h0402);
    wr(6'h00, 32'h5);
    check("R10 irq enabled", irq, 1);

    // R11 fault coincides with clear
    @(negedge clk);
    wr_en = 1; addr = 6'h20; wdata = 0;
    flt_valid = 1; flt_flags = 4'b0100; flt_code = 3'd5; flt_level = 2'd3; flt_addr = 32'h0BAD_0000;
    @(negedge clk); wr_en = 0; flt_valid = 0;
    rd(6'h20, d); check("R11 fresh status", d, 32'h3504);
    rd(6'h24, d); check("R11 fresh addr", d, 32'h0BAD_0000);
    check("R11 irq", irq, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule